// File: doc/BRIEF.md
# Boot Flash Command Interface

This block models the byte-wide command interface of a boot-block flash device. The array behind it is a synchronous RAM held inside the block. Each bus write is read as one of two things. It is a command byte, which selects what later reads return or starts an erase. Or, when the previous command was program setup, it is a data byte that is ANDed into the addressed array byte. Each bus read returns one of three things, chosen by the current mode: an array byte, a manufacturer or device identifier, or the status byte.

The mode register simply holds the last command byte that was accepted. Program and erase complete without any real device timing. An erase confirm fills the aligned block with 0xFF at one byte per clock. While that fill runs, a busy output is high and the request channel stalls. A parameter picks the 128 KiB or the 256 KiB variant. The variant sets the address width, the erase block size and the device identifier.

Requests use a valid/ready handshake. The block takes a request on a clock edge where `req_valid` and `req_ready` are both high. A requester must hold every request field stable until that edge. `req_ready` drops for one cycle after a program data write, and for the whole length of an erase fill. Read responses carry no back-pressure. `rsp_valid` pulses for exactly one cycle, in the cycle after a read is accepted, and `rsp_data` is only meaningful during that pulse.

Top module: `bootflash_cmd`

## Requirements
- R1: After reset the mode is read array, the status byte is 0x80 (bit 7 = ready), `busy` and `modified` are 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: An accepted read gives `rsp_valid` = 1 in the next cycle only. In read-array mode `rsp_data` is then the stored byte at the read address. No other cycle shows `rsp_valid`.
- R3: In identifier mode (command 0x90), a read at an even address returns 0x89. A read at an odd address returns 0x94 for the 128 KiB variant and 0x7C for the 256 KiB variant.
- R4: In every mode except read array (0xFF) and identifier, a read returns the status byte. When the mode is erase (0xD0), that read also sets status bit 7 after returning the old value.
- R5: In program-setup mode (0x40), the next write stores (old byte AND data) at its address and moves the mode to read status (0x70).
- R6: Writes of 0xFF, 0x90, 0x20, 0xB0 or 0x40 load the mode directly. A write of 0x70 loads read-status mode, except in erase mode, where it is ignored.
- R7: A write of 0x50 clears status bits 5:3 and sets the mode to read array. The other status bits are unchanged.
- R8: A write of 0xD0 in erase-setup mode (0x20) does three things. It clears status bits 7:6, enters erase mode, and fills with 0xFF the block that holds the address, aligned to the block size. The block is 4 KiB for the 128 KiB variant and 8 KiB for the 256 KiB variant. Bytes outside that block keep their values.
- R9: A write of 0xD0 in erase-suspend mode (0xB0) clears only status bit 6 and returns to erase mode without a fill. In any other mode it is ignored.
- R10: Outside program-setup mode, a write whose data is not one of the command codes leaves the mode and the status unchanged.
- R11: `modified` rises on the first program data write or erase confirm after reset and then stays high.
- R12: The fill writes one byte per clock. `busy` is high for exactly one cycle per block byte, starting in the cycle after the confirm is accepted. `req_ready` is low throughout the fill and in the cycle after a program data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_we | input | 1 | 1 = write (command or program data), 0 = read |
| req_addr | input | 17 or 18 | Byte address; the width follows the variant |
| req_wdata | input | 8 | Write data byte |
| rsp_valid | output | 1 | Read response valid, one cycle after an accepted read |
| rsp_data | output | 8 | Read response byte |
| busy | output | 1 | Erase fill in progress |
| modified | output | 1 | Array contents changed since reset |

## Verification
A wrong mode register does not show up on its own. It appears at the next read, which returns the wrong class of byte: array data where status is expected, or status where the identifier is expected. A status bit set or cleared when it should not be shows up only on a later status read. The read-sets-ready rule in erase mode is therefore checked with pairs of back-to-back status reads. A fill with the wrong base or length shows up as busy running the wrong number of cycles. It also shows up on later array reads, either inside the target block or just past its edge. Each of these faults therefore becomes visible within two requests of the stimulus that exposes it.

// File: rtl/bootflash_pkg.sv
package bootflash_pkg;

  typedef enum logic [7:0] {
    CMD_ARRAY  = 8'hFF,
    CMD_IDENT  = 8'h90,
    CMD_STAT   = 8'h70,
    CMD_CLR    = 8'h50,
    CMD_ESETUP = 8'h20,
    CMD_ESUSP  = 8'hB0,
    CMD_PSETUP = 8'h40,
    CMD_ECONF  = 8'hD0
  } fcmd_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_WB   = 2'd1,
    ENG_FILL = 2'd2
  } eng_state_e;

  localparam logic [7:0] ID_MFR      = 8'h89;
  localparam logic [7:0] ID_DEV_SMALL = 8'h94;
  localparam logic [7:0] ID_DEV_BIG   = 8'h7C;
  localparam logic [7:0] STATUS_RST   = 8'h80;

endpackage

// File: rtl/bf_store.sv
module bf_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bf_cmd_fsm.sv
module bf_cmd_fsm
  import bootflash_pkg::*;
#(
  parameter bit BIG = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_acc,
  input  logic       rd_acc,
  input  logic       addr_lsb,
  input  logic [7:0] wdata,
  output fcmd_e      mode_q,
  output logic       prog_go,
  output logic       erase_go,
  output logic       rsp_valid_q,
  output logic       rsp_arr_q,
  output logic [7:0] rsp_byte_q,
  output logic       modified_q
);
  localparam logic [7:0] DEV_ID = BIG ? ID_DEV_BIG : ID_DEV_SMALL;

  logic [7:0] status_q;

  always_comb begin
    prog_go  = wr_acc && (mode_q == CMD_PSETUP);
    erase_go = wr_acc && (mode_q == CMD_ESETUP) && (wdata == CMD_ECONF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= CMD_ARRAY;
      status_q    <= STATUS_RST;
      rsp_valid_q <= 1'b0;
      rsp_arr_q   <= 1'b0;
      rsp_byte_q  <= 8'h00;
      modified_q  <= 1'b0;
    end else begin
      rsp_valid_q <= rd_acc;
      if (rd_acc) begin
        case (mode_q)
          CMD_ARRAY: rsp_arr_q <= 1'b1;
          CMD_IDENT: begin
            rsp_arr_q  <= 1'b0;
            rsp_byte_q <= addr_lsb ? DEV_ID : ID_MFR;
          end
          default: begin
            rsp_arr_q  <= 1'b0;
            rsp_byte_q <= status_q;
            if (mode_q == CMD_ECONF) status_q[7] <= 1'b1;
          end
        endcase
      end
      if (wr_acc) begin
        if (mode_q == CMD_PSETUP) begin
          mode_q     <= CMD_STAT;
          modified_q <= 1'b1;
        end else begin
          case (wdata)
            CMD_ARRAY:  mode_q <= CMD_ARRAY;
            CMD_IDENT:  mode_q <= CMD_IDENT;
            CMD_ESETUP: mode_q <= CMD_ESETUP;
            CMD_ESUSP:  mode_q <= CMD_ESUSP;
            CMD_PSETUP: mode_q <= CMD_PSETUP;
            CMD_STAT:   if (mode_q != CMD_ECONF) mode_q <= CMD_STAT;
            CMD_CLR: begin
              status_q[5:3] <= 3'b000;
              mode_q        <= CMD_ARRAY;
            end
            CMD_ECONF: begin
              if (mode_q == CMD_ESETUP) begin
                status_q[7:6] <= 2'b00;
                mode_q        <= CMD_ECONF;
                modified_q    <= 1'b1;
              end else if (mode_q == CMD_ESUSP) begin
                status_q[6] <= 1'b0;
                mode_q      <= CMD_ECONF;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/bf_wr_engine.sv
module bf_wr_engine
  import bootflash_pkg::*;
#(
  parameter int ARR_AW   = 17,
  parameter int BLK_AW   = 12,
  parameter int STORE_AW = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_go,
  input  logic                erase_go,
  input  logic [ARR_AW-1:0]   cmd_addr,
  input  logic [7:0]          cmd_data,
  input  logic [7:0]          ram_q,
  output logic                idle,
  output logic                filling,
  output logic                wr_en,
  output logic [STORE_AW-1:0] wr_addr,
  output logic [7:0]          wr_data
);
  localparam int HI_W = ARR_AW - BLK_AW;

  eng_state_e          state_q;
  logic [ARR_AW-1:0]   base_q;
  logic [BLK_AW-1:0]   cnt_q;
  logic [7:0]          data_q;
  logic [ARR_AW-1:0]   cur_addr;

  always_comb begin
    idle     = (state_q == ENG_IDLE);
    filling  = (state_q == ENG_FILL);
    wr_en    = !idle;
    cur_addr = base_q | {{HI_W{1'b0}}, cnt_q};
    wr_addr  = cur_addr[STORE_AW-1:0];
    wr_data  = (state_q == ENG_WB) ? (ram_q & data_q) : 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
      data_q  <= 8'h00;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          cnt_q <= '0;
          if (prog_go) begin
            state_q <= ENG_WB;
            base_q  <= cmd_addr;
            data_q  <= cmd_data;
          end else if (erase_go) begin
            state_q <= ENG_FILL;
            base_q  <= {cmd_addr[ARR_AW-1:BLK_AW], {BLK_AW{1'b0}}};
          end
        end
        ENG_WB: state_q <= ENG_IDLE;
        ENG_FILL: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == {BLK_AW{1'b1}}) state_q <= ENG_IDLE;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bootflash_cmd.sv
module bootflash_cmd
  import bootflash_pkg::*;
#(
  parameter bit  BIG      = 1'b0,
  parameter int  STORE_AW = 11,
  localparam int ARR_AW   = BIG ? 18 : 17,
  localparam int BLK_AW   = BIG ? 13 : 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ARR_AW-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              busy,
  output logic              modified
);
  logic                wr_acc, rd_acc, acc;
  logic                prog_go, erase_go;
  logic                eng_idle, eng_fill;
  logic                rsp_arr_q;
  logic [7:0]          rsp_byte_q;
  logic [7:0]          ram_q;
  logic                st_we;
  logic [STORE_AW-1:0] st_waddr;
  logic [7:0]          st_wdata;
  fcmd_e               mode_q;

  always_comb begin
    req_ready = eng_idle;
    acc       = req_valid && req_ready;
    wr_acc    = acc && req_we;
    rd_acc    = acc && !req_we;
    busy      = eng_fill;
    rsp_data  = rsp_arr_q ? ram_q : rsp_byte_q;
  end

  bf_cmd_fsm #(.BIG(BIG)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_acc     (wr_acc),
    .rd_acc     (rd_acc),
    .addr_lsb   (req_addr[0]),
    .wdata      (req_wdata),
    .mode_q     (mode_q),
    .prog_go    (prog_go),
    .erase_go   (erase_go),
    .rsp_valid_q(rsp_valid),
    .rsp_arr_q  (rsp_arr_q),
    .rsp_byte_q (rsp_byte_q),
    .modified_q (modified)
  );

  bf_wr_engine #(.ARR_AW(ARR_AW), .BLK_AW(BLK_AW), .STORE_AW(STORE_AW)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog_go (prog_go),
    .erase_go(erase_go),
    .cmd_addr(req_addr),
    .cmd_data(req_wdata),
    .ram_q   (ram_q),
    .idle    (eng_idle),
    .filling (eng_fill),
    .wr_en   (st_we),
    .wr_addr (st_waddr),
    .wr_data (st_wdata)
  );

  bf_store #(.AW(STORE_AW), .DW(8)) u_store (
    .clk  (clk),
    .we   (st_we),
    .waddr(st_waddr),
    .wdata(st_wdata),
    .re   (acc),
    .raddr(req_addr[STORE_AW-1:0]),
    .rdata(ram_q)
  );
endmodule

// File: rtl/bf_checker.sv
module bf_checker
  import bootflash_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_we,
  input logic       addr0,
  input logic [7:0] req_wdata,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic       busy,
  input logic       modified,
  input fcmd_e      mode
);
  logic rd_take, wr_take;
  assign rd_take = req_valid && req_ready && !req_we;
  assign wr_take = req_valid && req_ready && req_we;

  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> rsp_valid);
  p_no_stray_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_take |=> !rsp_valid);
  p_id_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && mode == CMD_IDENT && !addr0) |=> (rsp_data == 8'h89));
  p_prog_to_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && mode == CMD_PSETUP) |=> (mode == CMD_STAT));
  p_stat_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && mode == CMD_ECONF && req_wdata == 8'h70) |=> (mode == CMD_ECONF));
  p_fill_marks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> modified);
  p_mod_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    modified |=> modified);
  p_stall_fill_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
endmodule

bind bootflash_cmd bf_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_we   (req_we),
  .addr0    (req_addr[0]),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_data (rsp_data),
  .busy     (busy),
  .modified (modified),
  .mode     (mode_q)
);

// File: tb/sim_bootflash_cmd.sv
module sim_bootflash_cmd;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, busy, modified;
  logic [7:0]  rsp_data;

  logic        b_valid = 1'b0, b_we = 1'b0;
  logic [17:0] b_addr = '0;
  logic [7:0]  b_wdata = '0;
  logic        b_ready, b_rsp_valid, b_busy, b_modified;
  logic [7:0]  b_rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bootflash_cmd #(.BIG(1'b0), .STORE_AW(14)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .modified(modified));

  bootflash_cmd #(.BIG(1'b1), .STORE_AW(8)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
    .req_we(b_we), .req_addr(b_addr), .req_wdata(b_wdata),
    .rsp_valid(b_rsp_valid), .rsp_data(b_rsp_data), .busy(b_busy), .modified(b_modified));

  // vector: {is_read, addr[19:0], byte, req}
  localparam int NV = 50;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 20'h1C000, 8'h20, 4'd8},   // R8 erase setup
    {1'b0, 20'h1C123, 8'hD0, 4'd8},   // R8 confirm, fills 0x1C000..0x1CFFF
    {1'b1, 20'h00000, 8'h00, 4'd8},   // R8 bits 7:6 cleared
    {1'b1, 20'h00000, 8'h80, 4'd4},   // R4 previous read set bit 7
    {1'b0, 20'h1D000, 8'h20, 4'd8},
    {1'b0, 20'h1D000, 8'hD0, 4'd8},
    {1'b0, 20'h00000, 8'h70, 4'd6},   // R6 ignored in erase mode
    {1'b1, 20'h00000, 8'h00, 4'd6},
    {1'b1, 20'h00000, 8'h80, 4'd6},   // R6 still erase mode
    {1'b0, 20'h00000, 8'hFF, 4'd6},
    {1'b1, 20'h1C010, 8'hFF, 4'd8},
    {1'b1, 20'h1DFFF, 8'hFF, 4'd8},
    {1'b0, 20'h00000, 8'h40, 4'd5},   // R5 program
    {1'b0, 20'h1C010, 8'hA5, 4'd5},
    {1'b1, 20'h00000, 8'h80, 4'd5},   // R5 now read status
    {1'b0, 20'h00000, 8'hFF, 4'd5},
    {1'b1, 20'h1C010, 8'hA5, 4'd5},
    {1'b0, 20'h00000, 8'h40, 4'd5},
    {1'b0, 20'h1C010, 8'h0F, 4'd5},
    {1'b0, 20'h00000, 8'hFF, 4'd5},
    {1'b1, 20'h1C010, 8'h05, 4'd5},   // R5 AND of A5 and 0F
    {1'b0, 20'h00000, 8'h90, 4'd3},
    {1'b1, 20'h1C000, 8'h89, 4'd3},   // R3 even
    {1'b1, 20'h1C001, 8'h94, 4'd3},   // R3 odd, small variant
    {1'b0, 20'h00000, 8'h12, 4'd10},  // R10 unknown code
    {1'b1, 20'h1C001, 8'h94, 4'd10},
    {1'b0, 20'h00000, 8'h50, 4'd7},   // R7 clear status
    {1'b1, 20'h1C010, 8'h05, 4'd7},
    {1'b0, 20'h00000, 8'h70, 4'd4},
    {1'b1, 20'h00000, 8'h80, 4'd4},
    {1'b0, 20'h00000, 8'h50, 4'd7},
    {1'b1, 20'h1C010, 8'h05, 4'd7},
    {1'b0, 20'h1C010, 8'hD0, 4'd9},   // R9 confirm ignored in read array
    {1'b1, 20'h1C010, 8'h05, 4'd9},
    {1'b0, 20'h1D000, 8'h20, 4'd9},
    {1'b0, 20'h1D000, 8'hD0, 4'd9},
    {1'b0, 20'h00000, 8'hB0, 4'd9},   // R9 suspend
    {1'b1, 20'h00000, 8'h00, 4'd9},
    {1'b1, 20'h00000, 8'h00, 4'd9},   // R9 suspend reads do not set ready
    {1'b0, 20'h00000, 8'hD0, 4'd9},   // R9 resume
    {1'b1, 20'h00000, 8'h00, 4'd9},
    {1'b1, 20'h00000, 8'h80, 4'd9},
    {1'b0, 20'h00000, 8'h40, 4'd8},
    {1'b0, 20'h1D000, 8'h3C, 4'd8},
    {1'b0, 20'h00000, 8'h20, 4'd8},
    {1'b0, 20'h1CFFF, 8'hD0, 4'd8},   // R8 unaligned confirm address
    {1'b0, 20'h00000, 8'hFF, 4'd8},
    {1'b1, 20'h1D000, 8'h3C, 4'd8},   // R8 next block untouched
    {1'b1, 20'h1CFFF, 8'hFF, 4'd8},
    {1'b1, 20'h1C010, 8'hFF, 4'd8}
  };

  task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a[16:0]; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic do_read(input logic [19:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a[16:0];
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid;
    d = rsp_data;
  endtask

  task automatic b_read(input logic [17:0] a, output logic [7:0] d);
    @(negedge clk);
    b_valid = 1'b1; b_we = 1'b0; b_addr = a;
    @(negedge clk);
    b_valid = 1'b0;
    d = b_rsp_data;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(1, "ready", 16'(req_ready), 16'd1);
    check(1, "busy", 16'(busy), 16'd0);
    check(1, "modified", 16'(modified), 16'd0);
    check(1, "rsp_valid", 16'(rsp_valid), 16'd0);
    do_write(20'h0, 8'h70);
    do_read(20'h0, d, v);
    check(1, "status after reset", 16'(d), 16'h80);
    check(2, "rsp_valid after read", 16'(v), 16'd1);
    do_write(20'h0, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) begin
        do_read(VEC[i][31:12], d, v);
        check(int'(VEC[i][3:0]), $sformatf("vec %0d", i), {8'(v), d}, {8'h01, VEC[i][11:4]});
      end else begin
        do_write(VEC[i][31:12], VEC[i][11:4]);
      end
    end

    // R11 after program and erase
    check(11, "modified set", 16'(modified), 16'd1);

    // R12 fill length and stall
    do_write(20'h1C000, 8'h20);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 17'h1C000; req_wdata = 8'hD0;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    n = 0;
    begin
      int rdy_bad = 0;
      while (busy && n < 20000) begin
        n++;
        if (req_ready) rdy_bad++;
        @(negedge clk);
      end
      check(12, "fill cycles", 16'(n), 16'd4096);
      check(12, "ready during fill", 16'(rdy_bad), 16'd0);
    end
    check(2, "no rsp after writes", 16'(rsp_valid), 16'd0);

    // R12 stall after program data
    do_write(20'h0, 8'h40);
    do_write(20'h1C020, 8'h11);
    check(12, "ready after program", 16'(req_ready), 16'd0);
    check(11, "modified sticky", 16'(modified), 16'd1);
    do_write(20'h0, 8'hFF);
    do_read(20'h1C020, d, v);
    check(2, "array byte after program", 16'(d), 16'h11);

    // R3 large variant identifier
    @(negedge clk);
    b_valid = 1'b1; b_we = 1'b1; b_addr = 18'h0; b_wdata = 8'h90;
    @(negedge clk);
    b_valid = 1'b0; b_we = 1'b0;
    b_read(18'h3C001, d);
    check(3, "big variant odd id", 16'(d), 16'h7C);
    b_read(18'h3C000, d);
    check(3, "big variant even id", 16'(d), 16'h89);
    check(11, "no modify on id reads", 16'(b_modified), 16'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule